// File: doc/BRIEF.md
# 8-bit ALU with Five-Flag Store

This block is the arithmetic and logic stage of a small 8-bit processor. It takes the accumulator on one input and a second byte on another. The second byte may come from a register, from an immediate field or from memory; the block does not care which. It computes add, add-with-carry, subtract, subtract-with-borrow, AND, XOR, OR, compare, increment and decrement. The result appears combinationally in the same cycle as the operation. A write strobe tells the register file whether to store the result.

Five condition flags are kept in a registered store inside the block: sign, zero, half carry, parity and carry. Each operation carries an update mask. Increment and decrement refresh every flag except carry, so the carry of a multi-byte sequence survives a loop counter. The stored carry feeds the carry-using operations. The flags are presented packed as one byte, ready for a push to the stack.

Increment and decrement act on the second input, not on the accumulator. Any register can then be routed through the block and written back to its own place.

Top module: `alu8_unit`

Operation codes on `op_code`:

| Code | Operation |
|------|-----------|
| 0 | ADD |
| 1 | ADC |
| 2 | SUB |
| 3 | SBB |
| 4 | AND |
| 5 | XOR |
| 6 | OR |
| 7 | CMP |
| 8 | INR |
| 9 | DCR |

Codes 10 to 15 are undefined.

There is no sequencing state. The only state is the flag store, which has two events:
- **HOLD**: no valid defined operation, so the flags are kept.
- **UPDATE**: a valid defined operation, so the masked fields are loaded on the clock edge.

## Requirements
- R1: ADD (code 0) drives `result` = (acc + opnd) mod 256. ADC (code 1) adds the stored carry as well. The new carry flag is the bit that leaves bit 7.
- R2: SUB (code 2) drives `result` = (acc − opnd) mod 256. SBB (code 3) also subtracts the stored carry. The new carry flag is 1 exactly when a borrow occurs, that is, when acc < opnd + borrow-in.
- R3: CMP (code 7) computes the difference and updates all flags exactly as SUB would. It keeps `result_we` low.
- R4: AND (4), XOR (5) and OR (6) give the bitwise result and clear the carry flag. AND sets the half-carry flag; XOR and OR clear it.
- R5: INR (8) and DCR (9) drive `result` = opnd ± 1 mod 256 and update sign, zero, half carry and parity. The carry flag keeps its stored value.
- R6: After an update, sign equals bit 7 of the result. Zero is 1 exactly when all 8 result bits are 0.
- R7: After an update, parity is 1 when the result holds an even number of 1 bits and 0 when the number is odd.
- R8: Half carry is the carry out of bit 3 of the adder. For ADD/ADC/INR the adder sums the operands directly. For SUB/SBB/CMP/DCR it adds the inverted second operand and the inverted borrow. For INR this makes half carry = (opnd[3:0] == 15); for DCR it makes half carry = (opnd[3:0] != 0).
- R9: `flags_byte` is {S, Z, 0, H, 0, P, 1, C}, from bit 7 down to bit 0. After reset all five flags are 0, so `flags_byte` = 8'h02.
- R10: The flags change only on a clock edge with `op_valid` high and a defined code (0 to 9). When `op_valid` is low, or the code is 10 to 15, `flags_byte` is unchanged.
- R11: `result_we` is high exactly when `op_valid` is high and the code is 0 to 6, 8 or 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag store |
| rst_n | input | 1 | Active-low asynchronous reset of the flag store |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select, encoding as listed above |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand: register, immediate or memory byte; the sole operand of INR/DCR |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| flags_byte | output | 8 | Registered flags packed per R9 |

## Verification
The bench sweeps every operation over a grid of accumulator and operand values. The grid includes 0, 255 and nibble-crossing values, and every point is run with stored carry both clear and set. This exercises the carry-in of ADC and SBB and the carry retention of INR and DCR. If subtract half carry were taken as a nibble borrow rather than an adder carry, the bench would catch it, as it would catch a DCR that touched carry or a CMP that raised the write strobe. It also checks that undefined codes and idle cycles leave the packed flag byte untouched. A design that loaded flags on them would corrupt the carry chain of the following operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    typedef logic [OP_W-1:0] alu_op_t;

    localparam alu_op_t OP_ADD = 4'd0;
    localparam alu_op_t OP_ADC = 4'd1;
    localparam alu_op_t OP_SUB = 4'd2;
    localparam alu_op_t OP_SBB = 4'd3;
    localparam alu_op_t OP_AND = 4'd4;
    localparam alu_op_t OP_XOR = 4'd5;
    localparam alu_op_t OP_OR  = 4'd6;
    localparam alu_op_t OP_CMP = 4'd7;
    localparam alu_op_t OP_INR = 4'd8;
    localparam alu_op_t OP_DCR = 4'd9;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic p;
        logic c;
    } flags_t;

    typedef struct packed {
        logic       defined;
        logic       write;
        logic       subtract;
        logic       use_carry;
        logic       is_logic;
        logic_sel_e lsel;
        logic       unary;
        logic       unary_dec;
        flags_t     mask;
    } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  alu_op_t   op,
    output alu_ctrl_t ctrl
);

    localparam flags_t MASK_ALL    = '{s: 1'b1, z: 1'b1, h: 1'b1, p: 1'b1, c: 1'b1};
    localparam flags_t MASK_KEEP_C = '{s: 1'b1, z: 1'b1, h: 1'b1, p: 1'b1, c: 1'b0};

    always_comb begin
        ctrl           = '0;
        ctrl.lsel      = LG_AND;
        unique case (op)
            OP_ADD: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.mask = MASK_ALL;
            end
            OP_ADC: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.use_carry = 1'b1;
                ctrl.mask    = MASK_ALL;
            end
            OP_SUB: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.subtract = 1'b1;
                ctrl.mask    = MASK_ALL;
            end
            OP_SBB: begin
                ctrl.defined   = 1'b1; ctrl.write = 1'b1; ctrl.subtract = 1'b1;
                ctrl.use_carry = 1'b1; ctrl.mask  = MASK_ALL;
            end
            OP_AND: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.is_logic = 1'b1;
                ctrl.lsel    = LG_AND; ctrl.mask = MASK_ALL;
            end
            OP_XOR: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.is_logic = 1'b1;
                ctrl.lsel    = LG_XOR; ctrl.mask = MASK_ALL;
            end
            OP_OR: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.is_logic = 1'b1;
                ctrl.lsel    = LG_OR; ctrl.mask = MASK_ALL;
            end
            OP_CMP: begin
                ctrl.defined = 1'b1; ctrl.subtract = 1'b1; ctrl.mask = MASK_ALL;
            end
            OP_INR: begin
                ctrl.defined = 1'b1; ctrl.write = 1'b1; ctrl.unary = 1'b1;
                ctrl.mask    = MASK_KEEP_C;
            end
            OP_DCR: begin
                ctrl.defined   = 1'b1; ctrl.write = 1'b1; ctrl.unary = 1'b1;
                ctrl.unary_dec = 1'b1; ctrl.mask  = MASK_KEEP_C;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int NIB = NIB_W
) (
    input  alu_ctrl_t      ctrl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           carry_in,
    output logic [W-1:0]   res,
    output logic           half,
    output logic           carry
);

    logic [W-1:0]   x_op;
    logic [W-1:0]   y_op;
    logic           c_op;
    logic [W:0]     sum;
    logic [NIB:0]   low_sum;
    logic [W-1:0]   lres;

    always_comb begin
        if (ctrl.unary) begin
            x_op = b;
            y_op = ctrl.unary_dec ? {W{1'b1}} : '0;
            c_op = ~ctrl.unary_dec;
        end else begin
            x_op = a;
            y_op = ctrl.subtract ? ~b : b;
            c_op = ctrl.subtract ? ~(ctrl.use_carry & carry_in)
                                 :  (ctrl.use_carry & carry_in);
        end
    end

    assign sum     = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, c_op};
    assign low_sum = {1'b0, x_op[NIB-1:0]} + {1'b0, y_op[NIB-1:0]} + {{NIB{1'b0}}, c_op};

    always_comb begin
        unique case (ctrl.lsel)
            LG_XOR:  lres = a ^ b;
            LG_OR:   lres = a | b;
            default: lres = a & b;
        endcase
    end

    always_comb begin
        if (ctrl.is_logic) begin
            res   = lres;
            half  = (ctrl.lsel == LG_AND);
            carry = 1'b0;
        end else begin
            res   = sum[W-1:0];
            half  = low_sum[NIB];
            carry = (ctrl.subtract && !ctrl.unary) ? ~sum[W] : sum[W];
        end
    end

endmodule

// File: rtl/alu8_flag_store.sv
module alu8_flag_store
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  flags_t       mask,
    input  logic [W-1:0] res,
    input  logic         half,
    input  logic         carry,
    output flags_t       flags_q
);

    typedef enum logic { ST_HOLD, ST_UPDATE } fs_ev_e;

    fs_ev_e ev;
    flags_t fresh;

    always_comb begin
        fresh.s = res[W-1];
        fresh.z = ~|res;
        fresh.h = half;
        fresh.p = ~^res;
        fresh.c = carry;
        ev      = load ? ST_UPDATE : ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            unique case (ev)
                ST_UPDATE: flags_q <= (flags_q & ~mask) | (fresh & mask);
                default:   flags_q <= flags_q;
            endcase
        end
    end

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [7:0]  acc_in,
    input  logic [7:0]  opnd_in,
    output logic [7:0]  result,
    output logic        result_we,
    output logic [7:0]  flags_byte
);

    alu_ctrl_t    ctrl;
    logic         dp_half;
    logic         dp_carry;
    flags_t       flags_q;

    alu8_decode u_dec (
        .op   (op_code),
        .ctrl (ctrl)
    );

    alu8_datapath #(.W(DATA_W), .NIB(NIB_W)) u_dp (
        .ctrl     (ctrl),
        .a        (acc_in),
        .b        (opnd_in),
        .carry_in (flags_q.c),
        .res      (result),
        .half     (dp_half),
        .carry    (dp_carry)
    );

    alu8_flag_store #(.W(DATA_W)) u_fs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_valid & ctrl.defined),
        .mask    (ctrl.mask),
        .res     (result),
        .half    (dp_half),
        .carry   (dp_carry),
        .flags_q (flags_q)
    );

    assign result_we  = op_valid & ctrl.write;
    assign flags_byte = {flags_q.s, flags_q.z, 1'b0, flags_q.h, 1'b0, flags_q.p, 1'b1, flags_q.c};

    // R6: zero flag follows the result of the updating operation
    a_r6_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= OP_DCR) |=> (flags_byte[6] == ($past(result) == 8'h00)));

    // R6: sign flag follows bit 7 of the result
    a_r6_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= OP_DCR) |=> (flags_byte[7] == $past(result[7])));

    // R7: parity flag marks an even count of ones
    a_r7_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= OP_DCR) |=> (flags_byte[2] == ~^$past(result)));

    // R5: increment/decrement keep the carry
    a_r5_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INR || op_code == OP_DCR)) |=> (flags_byte[0] == $past(flags_byte[0])));

    // R4: logical operations clear carry
    a_r4_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_AND || op_code == OP_XOR || op_code == OP_OR)) |=> !flags_byte[0]);

    // R3: compare never writes back
    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |-> !result_we);

    // R10: idle cycles and undefined codes hold the flags
    a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > OP_DCR) |=> $stable(flags_byte));

endmodule

// File: tb/sim_alu8_unit.sv
module sim_alu8_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op_code;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] flags_byte;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    bit  m_s, m_z, m_h, m_p, m_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .acc_in     (acc_in),
        .opnd_in    (opnd_in),
        .result     (result),
        .result_we  (result_we),
        .flags_byte (flags_byte)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0d a %0h b %0h)",
                     tag, what, act, exp, op_code, acc_in, opnd_in);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0, 1:    return "R1";
            2, 3:    return "R2";
            7:       return "R3";
            4, 5, 6: return "R4";
            8, 9:    return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic do_op(input int op, input int a, input int b, input bit act);
        int   r;
        int   cc;
        bit   nh, nc;
        bit   defd;
        logic [7:0] rb;
        logic [7:0] exp_byte;
        defd = (op <= 9);
        r = 0; nh = 1'b0; nc = m_c;
        case (op)
            0, 1: begin
                cc = (op == 1) ? int'(m_c) : 0;
                r  = a + b + cc;
                nc = (r > 255);
                nh = (((a & 15) + (b & 15) + cc) > 15);
            end
            2, 3, 7: begin
                cc = (op == 3) ? int'(m_c) : 0;
                r  = a - b - cc;
                nc = (r < 0);
                nh = (((a & 15) + ((~b) & 15) + 1 - cc) > 15);
            end
            4: begin r = a & b; nc = 1'b0; nh = 1'b1; end
            5: begin r = a ^ b; nc = 1'b0; nh = 1'b0; end
            6: begin r = a | b; nc = 1'b0; nh = 1'b0; end
            8: begin r = b + 1; nc = m_c; nh = ((b & 15) == 15); end
            9: begin r = b - 1; nc = m_c; nh = ((b & 15) != 0); end
            default: r = 0;
        endcase
        rb = r[7:0];

        @(negedge clk);
        op_valid = act;
        op_code  = op[3:0];
        acc_in   = a[7:0];
        opnd_in  = b[7:0];
        #1;
        if (act && defd) chk(op_tag(op), "result", int'(result), int'(rb));
        if (op == 7) chk("R3", "result_we", int'(result_we), 0);
        else         chk("R11", "result_we", int'(result_we), (act && defd) ? 1 : 0);

        if (act && defd) begin
            m_s = rb[7];
            m_z = (rb == 8'h00);
            m_p = ~^rb;
            m_h = nh;
            m_c = nc;
        end
        exp_byte = {m_s, m_z, 1'b0, m_h, 1'b0, m_p, 1'b1, m_c};

        @(posedge clk);
        #1;
        if (act && defd) begin
            chk("R6", "sign", int'(flags_byte[7]), int'(m_s));
            chk("R6", "zero", int'(flags_byte[6]), int'(m_z));
            chk("R8", "half", int'(flags_byte[4]), int'(m_h));
            chk("R7", "parity", int'(flags_byte[2]), int'(m_p));
            chk(op_tag(op), "carry", int'(flags_byte[0]), int'(m_c));
            chk("R9", "fixed bits", int'({flags_byte[5], flags_byte[3], flags_byte[1]}), 1);
        end else begin
            chk("R10", "flags held", int'(flags_byte), int'(exp_byte));
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        op_valid = 1'b0;
        op_code  = '0;
        acc_in   = '0;
        opnd_in  = '0;
        {m_s, m_z, m_h, m_p, m_c} = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset flags", int'(flags_byte), 8'h02);
        @(negedge clk);
        rst_n = 1'b1;

        for (int op = 0; op <= 9; op++) begin
            for (int ia = 0; ia <= 51; ia++) begin
                for (int ib = 0; ib <= 37; ib++) begin
                    for (int ci = 0; ci <= 1; ci++) begin
                        do_op(0, 255, ci, 1'b1);
                        do_op(op, ia * 5, (ib == 37) ? 255 : ib * 7, 1'b1);
                    end
                end
            end
        end

        // R10: idle cycles leave flags untouched
        do_op(0, 255, 1, 1'b1);
        do_op(0, 8'h80, 8'h80, 1'b0);
        do_op(7, 8'h00, 8'h01, 1'b0);
        // R10 and R11: undefined codes neither write nor touch flags
        for (int op = 10; op <= 15; op++) begin
            do_op(op, 8'h12, 8'h34, 1'b1);
        end
        // R3: compare equal sets zero, result not written
        do_op(7, 8'h5A, 8'h5A, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule